// File: doc/BRIEF.md
# Asynchronous SRAM Pin-Timing Monitor

This block watches the control, address and write-data pins of an asynchronous static RAM port. It samples them once per cycle of a fast clock whose period is `TICK_PS` picoseconds, and turns each sample into a bus mode. It tracks how long each relevant condition has lasted. Whenever a minimum interval of the memory's write or cycle timing is too short, it raises a sticky flag. It is meant to sit next to a memory controller, or a model of one, in a larger design and report misuse of the memory pins as it happens.

The write window is the part of time in which the active-low select is low, the active-high select is high and write enable is low. Each minimum is measured from the event that starts it to the sample that ends it:
- the window's own width;
- the time since both selects became active;
- the time since the address last changed;
- the time since the write data last changed.

The gap between two address changes is checked separately. An address change inside an open window is reported as its own fault. So is the host driving the data bus while the memory is reading. A saturating counter adds up every violation. One clear input wipes the flags and the counter.

Top module: `sram_pin_monitor`

## Requirements
- R1: `mode_o` shows the mode of the sample taken at the previous rising edge. The codes are 0 deselected (`sel_n_i` high or `sel_i` low), 1 output disabled (both selects active, `oe_n_i` and `we_n_i` high), 2 read (both selects active, `oe_n_i` low, `we_n_i` high) and 3 write (both selects active, `we_n_i` low, any `oe_n_i`). Deselection takes priority over every other mode.
- R2: A write window that lasts fewer than ceil(55 ns / tick) samples sets `err_o[0]` when it closes.
- R3: If both selects have been active together for fewer than ceil(60 ns / tick) samples when a write window closes, `err_o[1]` is set.
- R4: If the address last changed fewer than ceil(60 ns / tick) samples before the sample in which a write window closes, `err_o[2]` is set.
- R5: If the write data last changed fewer than ceil(30 ns / tick) samples before the sample in which a write window closes, `err_o[3]` is set.
- R6: An address change that comes fewer than ceil(70 ns / tick) samples after the previous address change sets `err_o[4]`. The first change after reset is never flagged.
- R7: An address change in a sample where the write window is open, and was also open in the previous sample, sets `err_o[5]`.
- R8: `host_drv_i` high in a sample whose mode is read sets `err_o[6]`. In the write, output-disabled and deselected modes it has no effect.
- R9: Flags are sticky. They stay set until `clr_i` is high in a sample. That sample zeroes every flag and the counter, and drops any violation detected in the same sample.
- R10: `viol_cnt_o` adds the number of rules violated in each sample and saturates at 16'hFFFF.
- R11: While `rst_ni` is low, `mode_o`, `err_o` and `viol_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, one tick per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clears sticky flags and the violation counter |
| sel_n_i | input | 1 | Active-low chip select pin |
| sel_i | input | 1 | Active-high chip select pin |
| oe_n_i | input | 1 | Active-low output enable pin |
| we_n_i | input | 1 | Active-low write enable pin |
| addr_i | input | ADDR_W | Address pins |
| wdata_i | input | DATA_W | Write data driven by the host |
| host_drv_i | input | 1 | Host data-bus drive enable |
| mode_o | output | 2 | Decoded mode of the last sample |
| err_o | output | 7 | Sticky per-rule violation flags |
| viol_cnt_o | output | 16 | Saturating violation count |

## Verification
Every result is registered once. The mode, each flag and the counter all reflect the sample taken at the rising edge just before. Interval rules fire on the first sample in which the window is closed. Address, contention and cycle-time faults fire on the very sample that carries the offending pins. The bench changes pins only just after a falling edge and reads the outputs at the following falling edge. It counts every interval in whole samples: ticks are 5 ns, so the limits are 11, 12, 12, 6 and 14 samples. Each test drives one side of one limit by a single sample.

// File: rtl/sram_mon_pkg.sv
`timescale 1ns/1ps
package sram_mon_pkg;

    typedef enum logic [1:0] {
        MODE_DESEL = 2'd0,
        MODE_ODIS  = 2'd1,
        MODE_READ  = 2'd2,
        MODE_WRITE = 2'd3
    } mode_e;

    localparam int NUM_RULES   = 7;
    localparam int RULE_WP     = 0;
    localparam int RULE_CW     = 1;
    localparam int RULE_AW     = 2;
    localparam int RULE_DW     = 3;
    localparam int RULE_RC     = 4;
    localparam int RULE_ASTAB  = 5;
    localparam int RULE_CONT   = 6;

    // minimum time in ps converted to whole ticks, rounded up
    function automatic int to_ticks(input int t_ps, input int tick_ps);
        return (t_ps + tick_ps - 1) / tick_ps;
    endfunction

endpackage

// File: rtl/sram_mon_decode.sv
`timescale 1ns/1ps
module sram_mon_decode
    import sram_mon_pkg::*;
(
    input  logic  sel_n_i,
    input  logic  sel_i,
    input  logic  oe_n_i,
    input  logic  we_n_i,
    output mode_e mode_o,
    output logic  both_sel_o,
    output logic  win_o
);

    always_comb begin
        both_sel_o = !sel_n_i && sel_i;
        win_o      = both_sel_o && !we_n_i;
        if (!both_sel_o)  mode_o = MODE_DESEL;
        else if (!we_n_i) mode_o = MODE_WRITE;
        else if (!oe_n_i) mode_o = MODE_READ;
        else              mode_o = MODE_ODIS;
    end

endmodule

// File: rtl/sram_mon_age.sv
`timescale 1ns/1ps
// Tracks a bus and reports how many samples its value has been held.
module sram_mon_age #(
    parameter int W  = 8,
    parameter int TW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  vec_i,
    output logic          changed_o,
    output logic [TW-1:0] age_o
);

    typedef struct packed {
        logic [W-1:0]  prev;
        logic [TW-1:0] age;
    } age_st_t;

    age_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        changed_o = (vec_i != st_q.prev);
        age_o     = st_q.age;
        st_d.prev = vec_i;
        if (changed_o)           st_d.age = TW'(1);
        else if (st_q.age != '1) st_d.age = st_q.age + TW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev <= '0;
            st_q.age  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sram_pin_monitor.sv
`timescale 1ns/1ps
module sram_pin_monitor
    import sram_mon_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 8,
    parameter int TICK_PS  = 5000,
    parameter int T_WP_PS  = 55000,
    parameter int T_CW_PS  = 60000,
    parameter int T_AW_PS  = 60000,
    parameter int T_DW_PS  = 30000,
    parameter int T_RC_PS  = 70000,
    parameter int CNT_W    = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clr_i,
    input  logic                 sel_n_i,
    input  logic                 sel_i,
    input  logic                 oe_n_i,
    input  logic                 we_n_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 host_drv_i,
    output logic [1:0]           mode_o,
    output logic [NUM_RULES-1:0] err_o,
    output logic [CNT_W-1:0]     viol_cnt_o
);

    localparam int WP_T  = to_ticks(T_WP_PS, TICK_PS);
    localparam int CW_T  = to_ticks(T_CW_PS, TICK_PS);
    localparam int AW_T  = to_ticks(T_AW_PS, TICK_PS);
    localparam int DW_T  = to_ticks(T_DW_PS, TICK_PS);
    localparam int RC_T  = to_ticks(T_RC_PS, TICK_PS);
    localparam int MAX1  = (WP_T > CW_T) ? WP_T : CW_T;
    localparam int MAX2  = (AW_T > DW_T) ? AW_T : DW_T;
    localparam int MAX3  = (MAX1 > MAX2) ? MAX1 : MAX2;
    localparam int MAX_T = (MAX3 > RC_T) ? MAX3 : RC_T;
    localparam int TW    = $clog2(MAX_T + 1) + 1;
    localparam int SUM_W = $clog2(NUM_RULES + 1);

    typedef struct packed {
        mode_e                mode;
        logic                 win;
        logic                 both_sel;
        logic [TW-1:0]        wp;
        logic [TW-1:0]        cw;
        logic [NUM_RULES-1:0] err;
        logic [CNT_W-1:0]     cnt;
    } mon_st_t;

    mon_st_t st_d, st_q;

    mode_e           mode_now;
    logic            win_now, both_now;
    logic            a_chg, d_chg;
    logic [TW-1:0]   a_age, d_age;

    sram_mon_decode u_dec (
        .sel_n_i    (sel_n_i),
        .sel_i      (sel_i),
        .oe_n_i     (oe_n_i),
        .we_n_i     (we_n_i),
        .mode_o     (mode_now),
        .both_sel_o (both_now),
        .win_o      (win_now)
    );

    sram_mon_age #(.W(ADDR_W), .TW(TW)) u_addr_age (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .vec_i     (addr_i),
        .changed_o (a_chg),
        .age_o     (a_age)
    );

    sram_mon_age #(.W(DATA_W), .TW(TW)) u_data_age (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .vec_i     (wdata_i),
        .changed_o (d_chg),
        .age_o     (d_age)
    );

    logic [NUM_RULES-1:0] viol;
    logic [SUM_W-1:0]     nsum;
    logic [CNT_W:0]       wide;
    logic                 win_end;

    always_comb begin
        st_d          = st_q;
        st_d.mode     = mode_now;
        st_d.win      = win_now;
        st_d.both_sel = both_now;

        // samples the window / both selects have been open, counting this one
        if (!win_now)           st_d.wp = '0;
        else if (!st_q.win)     st_d.wp = TW'(1);
        else if (st_q.wp != '1) st_d.wp = st_q.wp + TW'(1);

        if (!both_now)          st_d.cw = '0;
        else if (!st_q.both_sel) st_d.cw = TW'(1);
        else if (st_q.cw != '1) st_d.cw = st_q.cw + TW'(1);

        win_end = st_q.win && !win_now;

        viol             = '0;
        viol[RULE_WP]    = win_end && (st_q.wp < TW'(WP_T));
        viol[RULE_CW]    = win_end && (st_q.cw < TW'(CW_T));
        viol[RULE_AW]    = win_end && (a_age < TW'(AW_T));
        viol[RULE_DW]    = win_end && (d_age < TW'(DW_T));
        viol[RULE_RC]    = a_chg && (a_age < TW'(RC_T));
        viol[RULE_ASTAB] = a_chg && win_now && st_q.win;
        viol[RULE_CONT]  = host_drv_i && (mode_now == MODE_READ);

        nsum = '0;
        for (int i = 0; i < NUM_RULES; i++) begin
            nsum = nsum + SUM_W'(viol[i]);
        end
        wide = {1'b0, st_q.cnt} + (CNT_W+1)'(nsum);

        if (clr_i) begin
            st_d.err = '0;
            st_d.cnt = '0;
        end else begin
            st_d.err = st_q.err | viol;
            st_d.cnt = wide[CNT_W] ? '1 : wide[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_DESEL, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // data bus value only matters through its age; keep the unused term visible
    logic unused_dchg;
    assign unused_dchg = d_chg;

    assign mode_o     = st_q.mode;
    assign err_o      = st_q.err;
    assign viol_cnt_o = st_q.cnt;

endmodule

// File: rtl/sram_mon_chk.sv
`timescale 1ns/1ps
module sram_mon_chk
    import sram_mon_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 16
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 clr_i,
    input logic                 sel_n_i,
    input logic                 sel_i,
    input logic                 oe_n_i,
    input logic                 we_n_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 host_drv_i,
    input logic [1:0]           mode_o,
    input logic [NUM_RULES-1:0] err_o,
    input logic [CNT_W-1:0]     viol_cnt_o
);

    logic live_q;
    logic win;

    assign win = !sel_n_i && sel_i && !we_n_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    AST_MODE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_n_i || !sel_i) |=> (mode_o == 2'd0));  // R1

    AST_MODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win |=> (mode_o == 2'd3));  // R1

    AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && !clr_i && win && $past(win) && (addr_i != $past(addr_i)))
        |=> err_o[RULE_ASTAB]);  // R7

    AST_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && host_drv_i && !sel_n_i && sel_i && !oe_n_i && we_n_i)
        |=> err_o[RULE_CONT]);  // R8

    AST_STICKY_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((err_o & $past(err_o)) == $past(err_o)));  // R9

    AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> ((err_o == '0) && (viol_cnt_o == '0)));  // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (viol_cnt_o >= $past(viol_cnt_o)));  // R10

    AST_FLAG_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o != '0) |-> (viol_cnt_o != '0));  // R10

endmodule

bind sram_pin_monitor sram_mon_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .sel_n_i    (sel_n_i),
    .sel_i      (sel_i),
    .oe_n_i     (oe_n_i),
    .we_n_i     (we_n_i),
    .addr_i     (addr_i),
    .host_drv_i (host_drv_i),
    .mode_o     (mode_o),
    .err_o      (err_o),
    .viol_cnt_o (viol_cnt_o)
);

// File: tb/sram_pin_monitor_tb_top.sv
`timescale 1ns/1ps
module sram_pin_monitor_tb_top;
    import sram_mon_pkg::*;

    localparam int AW = 18;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1, we_n = 1'b1, hdrv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [1:0]    mode;
    logic [NUM_RULES-1:0] err;
    logic [15:0]   cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sram_pin_monitor dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .clr_i      (clr),
        .sel_n_i    (sel_n),
        .sel_i      (sel),
        .oe_n_i     (oe_n),
        .we_n_i     (we_n),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .host_drv_i (hdrv),
        .mode_o     (mode),
        .err_o      (err),
        .viol_cnt_o (cnt)
    );

    // {sel_n, sel, oe_n, we_n, expected mode}
    localparam logic [5:0] MTAB [8] = '{
        {4'b0100, 2'd3}, {4'b0110, 2'd3}, {4'b0101, 2'd2}, {4'b0111, 2'd1},
        {4'b1100, 2'd0}, {4'b0000, 2'd0}, {4'b1011, 2'd0}, {4'b0101, 2'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        sel_n = 1'b1; sel = 1'b0; oe_n = 1'b1; we_n = 1'b1; hdrv = 1'b0;
        step(16);
    endtask

    task automatic clear();
        clr = 1'b1; step(1); clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11 reset state
        step(3);
        chk("R11 mode in reset", 32'(mode), 32'd0);
        chk("R11 flags in reset", 32'(err), 32'd0);
        chk("R11 count in reset", 32'(cnt), 32'd0);
        rst_n = 1'b1;
        step(2);

        // R1 mode decode table
        for (int i = 0; i < 8; i++) begin
            {sel_n, sel, oe_n, we_n} = MTAB[i][5:2];
            step(1);
            chk("R1 mode table", 32'(mode), 32'(MTAB[i][1:0]));
        end
        idle();
        clear();
        chk("R9 clear flags", 32'(err), 32'd0);
        chk("R9 clear count", 32'(cnt), 32'd0);
        idle();

        // clean write, host drives during write (R8 no effect)
        addr = 18'h1234; step(14);
        sel_n = 1'b0; sel = 1'b1; we_n = 1'b0; wdata = 8'hA5; hdrv = 1'b1; step(12);
        chk("R1 write mode", 32'(mode), 32'd3);
        sel_n = 1'b1; we_n = 1'b1; step(1);
        hdrv = 1'b0;
        chk("R2 R3 R4 R5 clean write flags", 32'(err), 32'd0);
        chk("R8 host drive in write ignored", 32'(cnt), 32'd0);
        idle();

        // R2 short write pulse only
        sel_n = 1'b0; sel = 1'b1; step(2);
        we_n = 1'b0; step(10);
        sel_n = 1'b1; we_n = 1'b1; step(1);
        chk("R2 short pulse", 32'(err), 32'(1 << RULE_WP));
        chk("R2 count", 32'(cnt), 32'd1);
        clear(); idle();

        // R2 R3 both short, count by two (R10)
        sel_n = 1'b0; sel = 1'b1; we_n = 1'b0; step(5);
        sel_n = 1'b1; we_n = 1'b1; step(1);
        chk("R3 R2 both short", 32'(err), 32'((1 << RULE_WP) | (1 << RULE_CW)));
        chk("R10 two per sample", 32'(cnt), 32'd2);
        clear(); idle();

        // R3 window opened by active-high select, 11 samples
        sel_n = 1'b0; sel = 1'b0; we_n = 1'b0; step(5);
        chk("R1 high select low deselects", 32'(mode), 32'd0);
        sel = 1'b1; step(11);
        sel = 1'b0; step(1);
        chk("R3 select to end short", 32'(err), 32'(1 << RULE_CW));
        clear(); idle();

        // R5 data changes 4 samples before end
        sel_n = 1'b0; sel = 1'b1; we_n = 1'b0; wdata = 8'h11; step(12);
        wdata = 8'h22; step(4);
        sel_n = 1'b1; we_n = 1'b1; step(1);
        chk("R5 data setup short", 32'(err), 32'(1 << RULE_DW));
        clear(); idle();

        // R4 address changes as window opens, window 11 samples
        sel_n = 1'b0; sel = 1'b1; step(5);
        addr = 18'h2222; wdata = 8'h33; we_n = 1'b0; step(11);
        sel_n = 1'b1; we_n = 1'b1; step(1);
        chk("R4 address setup short", 32'(err), 32'(1 << RULE_AW));
        clear(); idle();

        // R6 two address changes 5 samples apart
        addr = 18'h0AAA; step(5);
        chk("R6 first change fine", 32'(err), 32'd0);
        addr = 18'h0BBB; step(1);
        chk("R6 cycle too short", 32'(err), 32'(1 << RULE_RC));
        chk("R6 count", 32'(cnt), 32'd1);
        clear(); idle();

        // R6 boundary: exactly 14 samples apart is fine
        addr = 18'h0CCC; step(14);
        addr = 18'h0DDD; step(1);
        chk("R6 cycle at limit", 32'(err), 32'd0);
        idle();

        // R7 address moves inside window
        sel_n = 1'b0; sel = 1'b1; we_n = 1'b0; step(8);
        addr = 18'h0EEE; step(12);
        sel_n = 1'b1; we_n = 1'b1; step(1);
        chk("R7 address unstable", 32'(err), 32'(1 << RULE_ASTAB));
        clear(); idle();

        // R8 contention in read; output disabled ignored
        sel_n = 1'b0; sel = 1'b1; oe_n = 1'b1; hdrv = 1'b1; step(1);
        chk("R8 output disabled ignored", 32'(err), 32'd0);
        oe_n = 1'b0; step(1);
        hdrv = 1'b0; step(1);
        chk("R8 read contention", 32'(err), 32'(1 << RULE_CONT));
        step(10);
        chk("R9 sticky flag", 32'(err), 32'(1 << RULE_CONT));
        chk("R9 sticky count", 32'(cnt), 32'd1);

        // R9 clear drops same-sample violation
        hdrv = 1'b1; clr = 1'b1; step(1); clr = 1'b0;
        chk("R9 clear drops same sample", 32'(err), 32'd0);
        chk("R9 clear drops count", 32'(cnt), 32'd0);
        step(1);
        chk("R9 next sample flags again", 32'(cnt), 32'd1);

        // R10 saturation
        step(65540);
        chk("R10 saturated", 32'(cnt), 32'hFFFF);
        chk("R10 flag kept", 32'(err), 32'(1 << RULE_CONT));
        idle();

        finish_run();
    end

endmodule